// File: doc/BRIEF.md
# Regulator Ready and Startup Sequencer

This block runs the digital side of a multiphase voltage regulator's power-up and its power-good reporting. It combines an enable input with a supply-lockout flag. Once both are good, it waits a fixed time, measured in clock cycles, and then issues a one-cycle start pulse to an external soft-start ramp. It waits in soft-start until the ramp reports completion, then enters regulation.

In regulation, the block compares a sampled output-voltage code against the target code from the DAC. Both codes are scaled so that one LSB is one millivolt. The acceptance window is lopsided: it reaches 225 mV below the target and 175 mV above it. The ready output follows that window, but it is frozen for as long as a voltage-identification transition is in flight.

Two strap inputs choose how many phases run. The block drives a per-phase enable mask that is active only during soft-start and regulation.

Top module: `vreg_seq_top`

## Requirements
- R1: During and right after reset, `ready`, `ss_start` and `pwm_en` are all zero, and the sequencer is idle.
- R2: Let the first rising edge that samples `en` and `uvlo_ok` both high be edge 0. Then `ss_start` is high for exactly the one cycle after edge DELAY_CYC, where DELAY_CYC = CLK_KHZ*DELAY_US/1000, and is low before and after that cycle.
- R3: If `en` or `uvlo_ok` falls while the delay is counting, the count is discarded. When both are good again, a full new DELAY_CYC wait is required before `ss_start`.
- R4: `pwm_en` is zero while idle and during the delay. It equals the phase mask from the cycle `ss_start` rises through soft-start and regulation. It returns to zero one edge after `en` or `uvlo_ok` is sampled low.
- R5: The phase mask, with bit i enabling phase i, is 4'b0111 when `strap4_hi`=1 and `strap3_hi`=0. It is 4'b0011 when both straps are 1, and 4'b1111 in every other case.
- R6: `ready` stays 0 outside regulation, including during soft-start with the output inside the window.
- R7: In regulation with no VID transition, `ready` takes the window result one edge after it is sampled. The lower bound is inclusive: `vout_code` = `vdac_code`-225 gives 1, and `vdac_code`-226 gives 0.
- R8: The upper bound is inclusive: `vout_code` = `vdac_code`+175 gives 1, and `vdac_code`+176 gives 0.
- R9: While `vid_busy` is high in regulation, `ready` keeps its value in both directions, whatever the codes are.
- R10: Losing `en` or `uvlo_ok` in regulation clears `ready` and `pwm_en` on the next edge. Restart then needs a new full delay and start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_ok | input | 1 | Supply is above the lockout threshold |
| en | input | 1 | Regulator enable |
| ss_done | input | 1 | External soft-start ramp has finished |
| vout_code | input | CODE_W | Output-voltage sample, 1 LSB = 1 mV |
| vdac_code | input | CODE_W | DAC target code, 1 LSB = 1 mV |
| vid_busy | input | 1 | Dynamic VID transition in progress |
| strap3_hi | input | 1 | Third-phase strap tied high |
| strap4_hi | input | 1 | Fourth-phase strap tied high |
| ready | output | 1 | Registered regulator-ready flag |
| ss_start | output | 1 | One-cycle soft-start start pulse |
| pwm_en | output | NUM_PH | Per-phase PWM enable mask |

## Verification
The bench builds the block with CLK_KHZ=1 and DELAY_US=16000, which gives a 16-cycle startup delay. The exact cycle of the start pulse, and a delay cut off and restarted partway through, can therefore be checked edge by edge within a few dozen cycles. CODE_W stays at 12 bits, so a target near 1000 mV puts both window edges, and one code past each, inside the code range. The straps, VID blanking and loss of enable are all driven from regulation, which the short delay reaches quickly.

// File: rtl/vreg_seq_pkg.sv
package vreg_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_DELAY = 2'd1,
    ST_SOFT  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/vreg_phase_decode.sv
module vreg_phase_decode #(
  parameter int NUM_PH = 4
) (
  input  logic              strap3_hi,
  input  logic              strap4_hi,
  output logic [NUM_PH-1:0] mask_o
);
  localparam int CNT_W = $clog2(NUM_PH + 1);

  logic [CNT_W-1:0] n_act;

  // top strap removes one phase; both straps remove two
  always_comb begin
    if (strap4_hi && strap3_hi)
      n_act = CNT_W'(NUM_PH - 2);
    else if (strap4_hi)
      n_act = CNT_W'(NUM_PH - 1);
    else
      n_act = CNT_W'(NUM_PH);
  end

  for (genvar g = 0; g < NUM_PH; g++) begin : g_mask
    assign mask_o[g] = (n_act > CNT_W'(g));
  end
endmodule

// File: rtl/vreg_window_cmp.sv
module vreg_window_cmp #(
  parameter int CODE_W   = 12,
  parameter int UNDER_MV = 225,
  parameter int OVER_MV  = 175
) (
  input  logic [CODE_W-1:0] vout_i,
  input  logic [CODE_W-1:0] vdac_i,
  output logic              in_win_o
);
  localparam int XW = CODE_W + 1;
  localparam logic [XW-1:0] UNDER_X = XW'(UNDER_MV);
  localparam logic [XW-1:0] OVER_X  = XW'(OVER_MV);

  logic [XW-1:0] vout_x, vdac_x;
  logic          low_ok, high_ok;

  assign vout_x  = {1'b0, vout_i};
  assign vdac_x  = {1'b0, vdac_i};
  // widened sums avoid wrap at either end of the code range
  assign low_ok  = (vout_x + UNDER_X) >= vdac_x;
  assign high_ok = vout_x <= (vdac_x + OVER_X);
  assign in_win_o = low_ok && high_ok;
endmodule

// File: rtl/vreg_seq_fsm.sv
module vreg_seq_fsm
  import vreg_seq_pkg::*;
#(
  parameter int DELAY_CYC = 2200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active_i,
  input  logic       ss_done_i,
  output seq_state_e state_o,
  output seq_state_e state_nxt_o,
  output logic       ss_start_o
);
  localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             ss_start_q;
  logic             delay_done;

  assign delay_done = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    if (!active_i) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:   state_d = ST_DELAY;
        ST_DELAY: if (delay_done) state_d = ST_SOFT;
        ST_SOFT:  if (ss_done_i) state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      cnt_q      <= '0;
      ss_start_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ss_start_q <= (state_q == ST_DELAY) && (state_d == ST_SOFT);
      if (state_q == ST_DELAY && state_d == ST_DELAY)
        cnt_q <= cnt_q + 1'b1;
      else
        cnt_q <= '0;
    end
  end

  assign state_o     = state_q;
  assign state_nxt_o = state_d;
  assign ss_start_o  = ss_start_q;

  AST_SS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ss_start_q |=> !ss_start_q); // R2
  AST_SS_IN_SOFT: assert property (@(posedge clk) disable iff (rst)
    ss_start_q |-> (state_q == ST_SOFT)); // R2
  AST_LOSS_TO_OFF: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (state_q == ST_OFF)); // R3
endmodule

// File: rtl/vreg_seq_top.sv
module vreg_seq_top
  import vreg_seq_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int NUM_PH   = 4,
  parameter int CLK_KHZ  = 1000,
  parameter int DELAY_US = 2200,
  parameter int UNDER_MV = 225,
  parameter int OVER_MV  = 175
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uvlo_ok,
  input  logic              en,
  input  logic              ss_done,
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] vdac_code,
  input  logic              vid_busy,
  input  logic              strap3_hi,
  input  logic              strap4_hi,
  output logic              ready,
  output logic              ss_start,
  output logic [NUM_PH-1:0] pwm_en
);
  localparam int DELAY_CYC = (CLK_KHZ * DELAY_US) / 1000;

  seq_state_e        state, state_nxt;
  logic              active;
  logic              in_win;
  logic [NUM_PH-1:0] ph_mask;
  logic              ready_q;
  logic [NUM_PH-1:0] pwm_q;

  assign active = en && uvlo_ok;

  vreg_seq_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .active_i   (active),
    .ss_done_i  (ss_done),
    .state_o    (state),
    .state_nxt_o(state_nxt),
    .ss_start_o (ss_start)
  );

  vreg_window_cmp #(
    .CODE_W  (CODE_W),
    .UNDER_MV(UNDER_MV),
    .OVER_MV (OVER_MV)
  ) u_win (
    .vout_i  (vout_code),
    .vdac_i  (vdac_code),
    .in_win_o(in_win)
  );

  vreg_phase_decode #(.NUM_PH(NUM_PH)) u_ph (
    .strap3_hi(strap3_hi),
    .strap4_hi(strap4_hi),
    .mask_o   (ph_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
    end else if (state != ST_RUN || !active) begin
      ready_q <= 1'b0;
    end else if (!vid_busy) begin
      ready_q <= in_win;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pwm_q <= '0;
    else if (state_nxt == ST_SOFT || state_nxt == ST_RUN)
      pwm_q <= ph_mask;
    else
      pwm_q <= '0;
  end

  assign ready  = ready_q;
  assign pwm_en = pwm_q;

  AST_PWM_OFF_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
    !active |=> (pwm_en == '0)); // R4
  AST_PWM_LOW_PAIR: assert property (@(posedge clk) disable iff (rst)
    (pwm_en != '0) |-> (pwm_en[1:0] == 2'b11)); // R5
  AST_READY_RUN_ONLY: assert property (@(posedge clk) disable iff (rst)
    ready |-> (state == ST_RUN)); // R6
  AST_READY_OUT_WIN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && active && !vid_busy && !in_win) |=> !ready); // R7
  AST_READY_VID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && active && vid_busy) |=> $stable(ready)); // R9
  AST_READY_DROP_LOSS: assert property (@(posedge clk) disable iff (rst)
    !active |=> !ready); // R10
endmodule

// File: tb/vreg_seq_top_bench.sv
module vreg_seq_top_bench;
  localparam int CODE_W = 12;
  localparam int NUM_PH = 4;
  localparam int DLY    = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              uvlo_ok = 1'b0, en = 1'b0, ss_done = 1'b0;
  logic [CODE_W-1:0] vout_code = '0, vdac_code = '0;
  logic              vid_busy = 1'b0, strap3_hi = 1'b0, strap4_hi = 1'b0;
  logic              ready, ss_start;
  logic [NUM_PH-1:0] pwm_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  vreg_seq_top #(
    .CODE_W(CODE_W), .NUM_PH(NUM_PH), .CLK_KHZ(1), .DELAY_US(16000),
    .UNDER_MV(225), .OVER_MV(175)
  ) u_vreg_seq_top (
    .clk(clk), .rst(rst), .uvlo_ok(uvlo_ok), .en(en), .ss_done(ss_done),
    .vout_code(vout_code), .vdac_code(vdac_code), .vid_busy(vid_busy),
    .strap3_hi(strap3_hi), .strap4_hi(strap4_hi),
    .ready(ready), .ss_start(ss_start), .pwm_en(pwm_en)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic go_run();
    en = 1'b1; uvlo_ok = 1'b1; ss_done = 1'b0;
    vdac_code = 12'd1000; vout_code = 12'd1000;
    for (int k = 0; k < DLY + 1; k++) tick();
    ss_done = 1'b1;
    tick();
    ss_done = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    chk("R1", "ready", 32'(ready), 0);
    chk("R1", "ss_start", 32'(ss_start), 0);
    chk("R1", "pwm_en", 32'(pwm_en), 0);
    rst = 1'b0;
    tick();
    chk("R1", "ready idle", 32'(ready), 0);
  endtask

  task automatic t_startup();
    bit pre_ok = 1;
    en = 1'b1; uvlo_ok = 1'b1;
    tick(); // edge 0
    for (int k = 1; k < DLY; k++) begin
      tick();
      if (ss_start !== 1'b0 || pwm_en !== '0) pre_ok = 0;
    end
    chk("R2", "no early start", 32'(pre_ok), 1);
    chk("R4", "pwm off in delay", 32'(pwm_en), 0);
    tick();
    chk("R2", "start pulse", 32'(ss_start), 1);
    chk("R4", "pwm on at start", 32'(pwm_en), 32'hF);
    vdac_code = 12'd1000; vout_code = 12'd1000;
    tick();
    chk("R2", "pulse ends", 32'(ss_start), 0);
    for (int k = 0; k < 3; k++) tick();
    chk("R6", "ready low in soft-start", 32'(ready), 0);
    en = 1'b0;
    tick();
    chk("R4", "pwm off after loss", 32'(pwm_en), 0);
  endtask

  task automatic t_abort();
    bit pre_ok = 1;
    en = 1'b1; uvlo_ok = 1'b1;
    for (int k = 0; k < 6; k++) tick();
    uvlo_ok = 1'b0;
    tick();
    uvlo_ok = 1'b1;
    tick(); // new edge 0
    for (int k = 1; k < DLY; k++) begin
      tick();
      if (ss_start !== 1'b0) pre_ok = 0;
    end
    chk("R3", "restart waits full delay", 32'(pre_ok), 1);
    tick();
    chk("R3", "start after full delay", 32'(ss_start), 1);
    en = 1'b0;
    tick();
  endtask

  task automatic t_window();
    go_run();
    chk("R7", "ready in window", 32'(ready), 1);
    vout_code = 12'd775; tick();
    chk("R7", "low bound inclusive", 32'(ready), 1);
    vout_code = 12'd774; tick();
    chk("R7", "below low bound", 32'(ready), 0);
    vout_code = 12'd1175; tick();
    chk("R8", "high bound inclusive", 32'(ready), 1);
    vout_code = 12'd1176; tick();
    chk("R8", "above high bound", 32'(ready), 0);
    vout_code = 12'd1000; tick();
    chk("R7", "back in window", 32'(ready), 1);
  endtask

  task automatic t_vid();
    vid_busy = 1'b1; vout_code = 12'd500;
    for (int k = 0; k < 3; k++) tick();
    chk("R9", "hold high", 32'(ready), 1);
    vid_busy = 1'b0; tick();
    chk("R9", "update after release", 32'(ready), 0);
    vid_busy = 1'b1; vout_code = 12'd1000;
    for (int k = 0; k < 3; k++) tick();
    chk("R9", "hold low", 32'(ready), 0);
    vid_busy = 1'b0; tick();
    chk("R9", "rise after release", 32'(ready), 1);
  endtask

  task automatic t_phase();
    strap4_hi = 1'b1; strap3_hi = 1'b0; tick();
    chk("R5", "three phases", 32'(pwm_en), 32'h7);
    strap3_hi = 1'b1; tick();
    chk("R5", "two phases", 32'(pwm_en), 32'h3);
    strap4_hi = 1'b0; tick();
    chk("R5", "third strap alone", 32'(pwm_en), 32'hF);
    strap3_hi = 1'b0; tick();
    chk("R5", "no straps", 32'(pwm_en), 32'hF);
  endtask

  task automatic t_drop();
    bit pre_ok = 1;
    uvlo_ok = 1'b0; tick();
    chk("R10", "ready off on lockout", 32'(ready), 0);
    chk("R10", "pwm off on lockout", 32'(pwm_en), 0);
    uvlo_ok = 1'b1;
    tick();
    for (int k = 1; k < DLY; k++) begin
      tick();
      if (ss_start !== 1'b0 || ready !== 1'b0) pre_ok = 0;
    end
    chk("R10", "new delay after loss", 32'(pre_ok), 1);
    tick();
    chk("R10", "start pulse again", 32'(ss_start), 1);
    en = 1'b0; tick();
  endtask

  initial begin
    t_reset();
    t_startup();
    t_abort();
    t_window();
    t_vid();
    t_phase();
    t_drop();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule